// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address used on each beat of a memory burst. A burst is opened by a load pulse that captures a starting column, a length code and an ordering choice. After that the block steps one beat each cycle in which the advance enable is high. For fixed-length bursts it flags the final beat. A full-page burst keeps running until it receives an explicit stop.

The fixed lengths are 1, 2, 4 and 8 beats. Within such a burst only the low column bits that the length spans may change, so the burst wraps inside its aligned block. Those bits either count upward (sequential order) or are XORed with the beat index (interleaved order). In full-page mode the address sweeps all 256 columns of a row, wraps from the top back to zero, and never flags a final beat.

A new access can arrive while a burst is running. A load pulse at that point drops what is left of the old burst and starts over from the new column with the full length. A command decoder sits in front of the block and the column decoder of the array sits behind it.

Top module: `burst_col_gen`

## Requirements
- R1: After synchronous reset, `busy` and `last` are 0 and `col` is 0.
- R2: A cycle with `load` high makes `busy` 1 and `col` equal to `start_col` from the next cycle on.
- R3: In sequential order (`order_sel`=0) with length 2, 4 or 8, beat k puts out the start column with its low log2(length) bits replaced by (low bits + k) modulo the length. Bits above that field never change.
- R4: In interleaved order (`order_sel`=1) with length 2, 4 or 8, beat k puts out the start column with its low log2(length) bits XORed with k.
- R5: A length-1 burst puts out only the start column and raises `last` on that same beat. An advance on that beat ends the burst.
- R6: `last` is high only on the final beat of a fixed-length burst. An advance while `last` is high drops `busy` to 0, and `col` then holds its final value.
- R7: While `adv` is low, the beat and `col` do not change.
- R8: In full-page mode the column rises by one on each advance and wraps from 255 to 0, whatever `order_sel` is. `last` stays 0 in this mode.
- R9: `stop` ends a full-page burst on the next cycle. In a fixed-length burst `stop` has no effect.
- R10: `load` during a running burst restarts from the new column with the full new length. `load` takes priority over `adv` and `stop` in the same cycle.
- R11: The `len_sel` codes are 000 for 1 beat, 001 for 2, 010 for 4, 011 for 8 and 111 for full page. The codes 100, 101 and 110 behave as a length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Start or restart a burst |
| start_col | input | 8 | Starting column, sampled with `load` |
| len_sel | input | 3 | Burst length code (R11) |
| order_sel | input | 1 | 0 sequential, 1 interleaved |
| adv | input | 1 | Advance one beat |
| stop | input | 1 | End a full-page burst |
| col | output | 8 | Column address of the current beat |
| busy | output | 1 | A burst is in progress |
| last | output | 1 | Current beat is the final one |

## Verification
Two collisions matter most. The first is a restart landing in the same cycle as an advance and a stop. The bench raises `load`, `adv` and `stop` together in the middle of an 8-beat burst. It then expects the next cycle to show the new start column, with `busy` still high and the full new interleaved length to follow. The second is a stop arriving on a fixed-length burst in a cycle that also advances. The bench expects that cycle to act as a plain advance, so the burst runs to its normal final beat.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int COL_W = 8;

    typedef enum logic [2:0] {
        LEN_1    = 3'b000,
        LEN_2    = 3'b001,
        LEN_4    = 3'b010,
        LEN_8    = 3'b011,
        LEN_PAGE = 3'b111
    } burst_len_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } burst_ord_e;

    typedef struct packed {
        logic [COL_W-1:0] base;
        burst_len_e       len;
        burst_ord_e       ord;
    } burst_cfg_t;

    // Low-bit field that a burst of the given length may touch.
    function automatic logic [COL_W-1:0] wrap_mask(burst_len_e l);
        case (l)
            LEN_2:    return COL_W'(1);
            LEN_4:    return COL_W'(3);
            LEN_8:    return COL_W'(7);
            LEN_PAGE: return '1;
            default:  return '0;
        endcase
    endfunction

    function automatic logic is_page(burst_len_e l);
        return l == LEN_PAGE;
    endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
#(
    parameter int W = COL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  burst_cfg_t       cfg_in,
    input  logic             adv,
    input  logic             stop,
    output burst_cfg_t       cfg_q,
    output logic [W-1:0]     beat,
    output logic             busy,
    output logic             last
);

    logic [W-1:0] mask;
    logic         page;

    always_comb begin
        mask = W'(wrap_mask(cfg_q.len));
        page = is_page(cfg_q.len);
        last = busy && !page && (beat == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{base: '0, len: LEN_1, ord: ORD_SEQ};
            beat  <= '0;
            busy  <= 1'b0;
        end else if (load) begin
            cfg_q <= cfg_in;
            beat  <= '0;
            busy  <= 1'b1;
        end else if (busy) begin
            if (stop && page) begin
                busy <= 1'b0;
            end else if (adv) begin
                if (last) busy <= 1'b0;
                else      beat <= beat + 1'b1;
            end
        end
    end

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (busy && beat == '0));

    // R6
    end_on_last_chk: assert property (@(posedge clk) disable iff (rst)
        (last && adv && !load) |=> !busy);

    // R9
    page_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && page && stop && !load) |=> !busy);

    // R7
    hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load) |=> $stable(beat));

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
    import burst_pkg::*;
#(
    parameter int W = COL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  burst_cfg_t   cfg,
    input  logic [W-1:0] beat,
    output logic [W-1:0] col
);

    logic [W-1:0] mask;
    logic [W-1:0] low;
    logic         use_xor;

    always_comb begin
        mask    = W'(wrap_mask(cfg.len));
        use_xor = (cfg.ord == ORD_XOR) && !is_page(cfg.len);
        low     = use_xor ? (cfg.base ^ beat) : (cfg.base + beat);
        col     = (cfg.base & ~mask) | (low & mask);
    end

    // R3
    block_confine_chk: assert property (@(posedge clk) disable iff (rst)
        !is_page(cfg.len) |-> ((col ^ cfg.base) & ~mask) == '0);

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_pkg::*;
#(
    parameter int W = COL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] start_col,
    input  logic [2:0]   len_sel,
    input  logic         order_sel,
    input  logic         adv,
    input  logic         stop,
    output logic [W-1:0] col,
    output logic         busy,
    output logic         last
);

    burst_cfg_t   cfg_in;
    burst_cfg_t   cfg_q;
    logic [W-1:0] beat;

    always_comb begin
        cfg_in.base = start_col;
        cfg_in.len  = burst_len_e'(len_sel);
        cfg_in.ord  = burst_ord_e'(order_sel);
    end

    burst_beat_ctr #(.W(W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .cfg_in (cfg_in),
        .adv    (adv),
        .stop   (stop),
        .cfg_q  (cfg_q),
        .beat   (beat),
        .busy   (busy),
        .last   (last)
    );

    burst_col_map #(.W(W)) u_map (
        .clk  (clk),
        .rst  (rst),
        .cfg  (cfg_q),
        .beat (beat),
        .col  (col)
    );

    // R2
    load_col_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (col == $past(start_col)));

    // R8
    page_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && is_page(cfg_q.len) && adv && !stop && !load)
            |=> (col == W'($past(col) + 1'b1)));

    // R8
    page_no_last_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && is_page(cfg_q.len)) |-> !last);

endmodule

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;

    logic       clk = 1'b0;
    logic       rst, load, order_sel, adv, stop;
    logic [7:0] start_col;
    logic [2:0] len_sel;
    logic [7:0] col;
    logic       busy, last;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    burst_col_gen u0 (
        .clk(clk), .rst(rst), .load(load), .start_col(start_col),
        .len_sel(len_sel), .order_sel(order_sel), .adv(adv), .stop(stop),
        .col(col), .busy(busy), .last(last)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int beats_of(input logic [2:0] code);
        case (code)
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int s, input int n, input int o, input int k);
        int lo, blk;
        blk = s - (s % n);
        lo  = s % n;
        if (o != 0) return blk + (lo ^ k);
        return blk + ((lo + k) % n);
    endfunction

    task automatic start(input int s, input logic [2:0] code, input logic o);
        load = 1; start_col = 8'(s); len_sel = code; order_sel = o; adv = 0; stop = 0;
        @(negedge clk);
        load = 0;
    endtask

    task automatic t_reset();
        rst = 1; load = 0; adv = 0; stop = 0; start_col = 0; len_sel = 0; order_sel = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 last", last, 0);
        chk("R1 col", col, 0);
    endtask

    task automatic t_burst(input string req, input int s, input logic [2:0] code, input logic o);
        int n;
        n = beats_of(code);
        start(s, code, o);
        chk("R2 busy", busy, 1);
        for (int k = 0; k < n; k++) begin
            chk(req, col, exp_col(s, n, o, k));
            chk("R6 last", last, (k == n - 1) ? 1 : 0);
            adv = 1;
            @(negedge clk);
        end
        adv = 0;
        chk("R6 busy after end", busy, 0);
        chk("R6 col holds", col, exp_col(s, n, o, n - 1));
    endtask

    task automatic t_hold();
        start(8'h12, 3'b010, 1'b0);
        repeat (2) @(negedge clk);
        chk("R7 col held", col, 8'h12);
        adv = 1; @(negedge clk); adv = 0;
        chk("R7 step", col, 8'h13);
        @(negedge clk);
        chk("R7 col held again", col, 8'h13);
        adv = 1; repeat (3) @(negedge clk); adv = 0;
    endtask

    task automatic t_page();
        start(8'hFC, 3'b111, 1'b1);
        for (int k = 0; k < 6; k++) begin
            chk("R8 page col", col, (8'hFC + k) % 256);
            chk("R8 no last", last, 0);
            adv = 1;
            @(negedge clk);
        end
        chk("R8 still busy", busy, 1);
        stop = 1; @(negedge clk); stop = 0; adv = 0;
        chk("R9 stop ends page", busy, 0);
    endtask

    task automatic t_stop_ignored();
        start(8'h08, 3'b010, 1'b0);
        adv = 1; @(negedge clk);
        stop = 1; @(negedge clk); stop = 0;
        chk("R9 stop ignored busy", busy, 1);
        chk("R9 stop ignored col", col, 8'h0A);
        @(negedge clk);
        chk("R9 reaches last", last, 1);
        @(negedge clk); adv = 0;
        chk("R9 ends normally", busy, 0);
    endtask

    task automatic t_reload();
        start(8'h05, 3'b011, 1'b0);
        adv = 1; repeat (2) @(negedge clk);
        chk("R3 pre-reload col", col, 8'h07);
        load = 1; stop = 1; start_col = 8'h43; len_sel = 3'b010; order_sel = 1;
        @(negedge clk);
        load = 0; stop = 0;
        chk("R10 reload col", col, 8'h43);
        chk("R10 reload busy", busy, 1);
        chk("R10 reload last", last, 0);
        @(negedge clk); chk("R10 beat1", col, 8'h42);
        @(negedge clk); chk("R10 beat2", col, 8'h41);
        @(negedge clk); chk("R10 beat3", col, 8'h40);
        chk("R10 full new length last", last, 1);
        @(negedge clk); adv = 0;
        chk("R10 done", busy, 0);
    endtask

    task automatic t_reserved();
        start(8'h6B, 3'b101, 1'b0);
        chk("R11 reserved col", col, 8'h6B);
        chk("R11 reserved last", last, 1);
        adv = 1; @(negedge clk); adv = 0;
        chk("R11 reserved ends", busy, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_burst("R5 len1", 8'h37, 3'b000, 1'b0);
        t_burst("R3 seq len2", 8'h21, 3'b001, 1'b0);
        t_burst("R3 seq len4", 8'h5E, 3'b010, 1'b0);
        t_burst("R3 seq len8", 8'hFD, 3'b011, 1'b0);
        t_burst("R4 xor len2", 8'h11, 3'b001, 1'b1);
        t_burst("R4 xor len4", 8'h9A, 3'b010, 1'b1);
        t_burst("R4 xor len8", 8'hC5, 3'b011, 1'b1);
        t_hold();
        t_page();
        t_stop_ignored();
        t_reload();
        t_reserved();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule